// File: doc/BRIEF.md
# Parallel Configuration Byte Loader

This block acts as the master of a configuration load. It reads configuration bytes from an external byte-wide memory and sends them out as one continuous serial stream. The block generates the memory address itself. A mode input, sampled at start, chooses the starting point and direction of the address:
- ascending from the bottom of the 64K space, or
- descending from the top of the 64K space.

Each byte is read with a single-cycle read strobe and placed in a holding register. The byte is then shifted out least significant bit first, timed by a configuration clock that the block derives from its system clock. The holding register is refilled while the current byte is still shifting, so there is no gap between bytes.

Two limits are latched at start:
- a keep count, which sets how many leading bits belong to the local device;
- a stream length, which sets the total number of bits.

The first bits of the stream appear on the local data output with a qualifier. The remaining bits go to a chain output that feeds the data input of a downstream device running on the same configuration clock. When the full length has been sent, a done flag rises and the block goes quiet until the next start.

Top module: `cfg_byte_loader`

## Requirements
- R1: After reset, until the first start, mem_rd, cfg_clk, done, keep_en and keep_data are 0, chain_out is 1 and mem_addr is 16'h0000.
- R2: With mode_desc=0 at start, the reads address 16'h0000, 16'h0001, 16'h0002, … in order.
- R3: With mode_desc=1 at start, the reads address 16'hFFFF, 16'hFFFE, … in order.
- R4: Stream bit n is bit (n mod 8) of the byte read by the (n/8)-th read, so bit 0 goes first. The stream outputs change only while cfg_clk is low.
- R5: cfg_clk has a period of 2*CLK_HALF system clocks with equal high and low times. Consecutive rising edges within one load are exactly that far apart, including across byte boundaries.
- R6: For stream bits with index below the latched keep count, keep_en=1 and keep_data carries the bit at the cfg_clk rising edge, and chain_out is 1.
- R7: For stream bits with index at or above the keep count, chain_out carries the bit, and keep_en and keep_data are 0.
- R8: mem_rd is a one-cycle pulse, mem_data is captured in that cycle, and a load of L bits issues exactly ceil(L/8) reads.
- R9: done rises after exactly L rising edges of cfg_clk. While done is 1, cfg_clk and mem_rd stay 0 and done holds until the next start.
- R10: A start pulse at any time restarts the load from the first address of the newly sampled mode with cleared counters. Changing mode_desc, keep_bits or stream_bits after start has no effect.
- R11: A start with stream_bits=0 sets done in the next cycle, with no read and no cfg_clk edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Synchronous start / restart pulse |
| mode_desc | input | 1 | 0: ascending from 0000, 1: descending from FFFF (sampled at start) |
| keep_bits | input | CNT_W | Number of leading bits kept locally (sampled at start) |
| stream_bits | input | CNT_W | Total stream length in bits (sampled at start) |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd | output | 1 | Read strobe, one cycle per byte |
| mem_data | input | 8 | Memory data, valid while mem_rd is 1 |
| cfg_clk | output | 1 | Generated configuration clock |
| keep_data | output | 1 | Local serial bit |
| keep_en | output | 1 | Local bit qualifier |
| chain_out | output | 1 | Serial data toward the next device in the chain |
| done | output | 1 | Load complete |

## Verification
A corrupted address register shows up on mem_addr at the next read strobe. Reads come every eight configuration clocks, so a wrong address is seen within 16*CLK_HALF system cycles. A wrong fill or shift count in the serializer shows as a wrong bit or a stretched cfg_clk period at the next byte boundary. A broken bit counter moves either the keep/chain split point or the cycle in which done rises, and both are compared edge by edge against the expected stream.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_RUN  = 2'd1,
    LD_DONE = 2'd2
  } ld_state_e;
endpackage

// File: rtl/cfg_clk_gen.sv
module cfg_clk_gen #(
  parameter int unsigned CLK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic cfg_clk,
  output logic shift_step
);
  localparam int unsigned PH_W = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_HALF - 1);

  logic [PH_W-1:0] phase_q, phase_d;
  logic            cclk_q, cclk_d;
  logic            tick;

  assign tick = (phase_q == PH_LAST);

  always_comb begin
    phase_d = phase_q;
    cclk_d  = cclk_q;
    if (clr || !en) begin
      phase_d = '0;
      cclk_d  = 1'b0;
    end else if (tick) begin
      phase_d = '0;
      cclk_d  = ~cclk_q;
    end else begin
      phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      cclk_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cclk_q  <= cclk_d;
    end
  end

  assign cfg_clk    = cclk_q;
  assign shift_step = en && !clr && tick && cclk_q;

  // R5
  clk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr || !en) |=> !cfg_clk);

  // R5
  clk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !tick) |=> $stable(cfg_clk));
endmodule

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              desc_in,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              desc_q, desc_d;

  always_comb begin
    addr_d = addr_q;
    desc_d = desc_q;
    if (start) begin
      desc_d = desc_in;
      addr_d = desc_in ? {ADDR_W{1'b1}} : '0;
    end else if (advance) begin
      addr_d = desc_q ? (addr_q - 1'b1) : (addr_q + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      desc_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      desc_q <= desc_d;
    end
  end

  assign addr = addr_q;

  // R2 R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !start) |=> (addr == ($past(desc_q) ? $past(addr) - 1'b1
                                                    : $past(addr) + 1'b1)));

  // R10
  addr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (addr == ($past(desc_in) ? {ADDR_W{1'b1}} : {ADDR_W{1'b0}})));
endmodule

// File: rtl/cfg_serializer.sv
module cfg_serializer
  import cfg_loader_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic              rd_fire,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic              shift_step,
  input  logic              more_bits,
  output logic              hold_full,
  output logic              sr_valid,
  output logic              ser_bit
);
  localparam int unsigned SC_W = $clog2(BYTE_W) + 1;
  localparam logic [SC_W-1:0] SC_FULL = SC_W'(BYTE_W);
  localparam logic [SC_W-1:0] SC_ONE  = SC_W'(1);

  logic [BYTE_W-1:0] hold_q, hold_d;
  logic              hfull_q, hfull_d;
  logic [BYTE_W-1:0] sr_q, sr_d;
  logic [SC_W-1:0]   scnt_q, scnt_d;
  logic              load;

  assign load = run && hfull_q &&
                ((scnt_q == '0) || (shift_step && scnt_q == SC_ONE));

  always_comb begin
    hold_d  = hold_q;
    hfull_d = hfull_q;
    sr_d    = sr_q;
    scnt_d  = scnt_q;
    if (clr) begin
      hfull_d = 1'b0;
      scnt_d  = '0;
    end else begin
      if (rd_fire) begin
        hold_d  = rd_data;
        hfull_d = 1'b1;
      end else if (load) begin
        hfull_d = 1'b0;
      end
      if (load) begin
        sr_d   = hold_q;
        scnt_d = SC_FULL;
      end else if (shift_step && scnt_q != '0) begin
        sr_d   = {1'b0, sr_q[BYTE_W-1:1]};
        scnt_d = scnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      hfull_q <= 1'b0;
      sr_q    <= '0;
      scnt_q  <= '0;
    end else begin
      hold_q  <= hold_d;
      hfull_q <= hfull_d;
      sr_q    <= sr_d;
      scnt_q  <= scnt_d;
    end
  end

  assign hold_full = hfull_q;
  assign sr_valid  = (scnt_q != '0);
  assign ser_bit   = sr_q[0];

  // R5
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && shift_step && scnt_q == SC_ONE && more_bits) |-> hfull_q);

  // R8
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |-> !hfull_q);
endmodule

// File: rtl/cfg_loader_ctrl.sv
module cfg_loader_ctrl
  import cfg_loader_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] keep_cfg,
  input  logic [CNT_W-1:0] total_cfg,
  input  logic             shift_step,
  input  logic             rd_fire,
  output logic             run,
  output logic             done,
  output logic             fetch_more,
  output logic             more_bits,
  output logic             keep_sel
);
  localparam int unsigned FC_W = CNT_W + 1;
  localparam logic [FC_W-1:0] FC_STEP = FC_W'(BYTE_W);

  ld_state_e        st_q, st_d;
  logic [CNT_W-1:0] bcnt_q, bcnt_d;
  logic [FC_W-1:0]  fcnt_q, fcnt_d;
  logic [CNT_W-1:0] keep_q, keep_d;
  logic [CNT_W-1:0] total_q, total_d;
  logic             last_bit;

  assign last_bit = (bcnt_q == total_q - 1'b1);

  always_comb begin
    st_d    = st_q;
    bcnt_d  = bcnt_q;
    fcnt_d  = fcnt_q;
    keep_d  = keep_q;
    total_d = total_q;
    if (start) begin
      keep_d  = keep_cfg;
      total_d = total_cfg;
      bcnt_d  = '0;
      fcnt_d  = '0;
      st_d    = (total_cfg == '0) ? LD_DONE : LD_RUN;
    end else if (st_q == LD_RUN) begin
      if (rd_fire) begin
        fcnt_d = fcnt_q + FC_STEP;
      end
      if (shift_step) begin
        bcnt_d = bcnt_q + 1'b1;
        if (last_bit) begin
          st_d = LD_DONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= LD_IDLE;
      bcnt_q  <= '0;
      fcnt_q  <= '0;
      keep_q  <= '0;
      total_q <= '0;
    end else begin
      st_q    <= st_d;
      bcnt_q  <= bcnt_d;
      fcnt_q  <= fcnt_d;
      keep_q  <= keep_d;
      total_q <= total_d;
    end
  end

  assign run        = (st_q == LD_RUN);
  assign done       = (st_q == LD_DONE);
  assign fetch_more = (fcnt_q < {1'b0, total_q});
  assign more_bits  = !last_bit;
  assign keep_sel   = (bcnt_q < keep_q);

  // R11
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && total_cfg == '0) |=> done);

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned CLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_desc,
  input  logic [CNT_W-1:0]  keep_bits,
  input  logic [CNT_W-1:0]  stream_bits,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [BYTE_W-1:0] mem_data,
  output logic              cfg_clk,
  output logic              keep_data,
  output logic              keep_en,
  output logic              chain_out,
  output logic              done
);
  logic run, fetch_more, more_bits, keep_sel;
  logic hold_full, sr_valid, ser_bit;
  logic shift_step, clk_en, rd_fire, active;

  assign rd_fire = run && !start && !hold_full && fetch_more;
  assign clk_en  = run && sr_valid;
  assign active  = run && sr_valid;

  cfg_loader_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .keep_cfg   (keep_bits),
    .total_cfg  (stream_bits),
    .shift_step (shift_step),
    .rd_fire    (rd_fire),
    .run        (run),
    .done       (done),
    .fetch_more (fetch_more),
    .more_bits  (more_bits),
    .keep_sel   (keep_sel)
  );

  cfg_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .desc_in (mode_desc),
    .advance (rd_fire),
    .addr    (mem_addr)
  );

  cfg_serializer u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (start),
    .run        (run),
    .rd_fire    (rd_fire),
    .rd_data    (mem_data),
    .shift_step (shift_step),
    .more_bits  (more_bits),
    .hold_full  (hold_full),
    .sr_valid   (sr_valid),
    .ser_bit    (ser_bit)
  );

  cfg_clk_gen #(.CLK_HALF(CLK_HALF)) u_clk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (start),
    .en         (clk_en),
    .cfg_clk    (cfg_clk),
    .shift_step (shift_step)
  );

  assign mem_rd    = rd_fire;
  assign keep_en   = active && keep_sel;
  assign keep_data = active && keep_sel && ser_bit;
  assign chain_out = (active && !keep_sel) ? ser_bit : 1'b1;

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_rd && !cfg_clk));

  // R8
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  // R6 R7
  route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    keep_en |-> chain_out);
endmodule

// File: tb/cfg_byte_loader_bench.sv
module cfg_byte_loader_bench;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 16;
  localparam int HALF   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mode_desc = 1'b0;
  logic [CNT_W-1:0] keep_bits = '0;
  logic [CNT_W-1:0] stream_bits = '0;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_rd;
  logic [7:0] mem_data;
  logic cfg_clk, keep_data, keep_en, chain_out, done;

  int n_tests = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cfg_byte_loader u_cfg_byte_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_desc(mode_desc),
    .keep_bits(keep_bits), .stream_bits(stream_bits),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_data(mem_data),
    .cfg_clk(cfg_clk), .keep_data(keep_data), .keep_en(keep_en),
    .chain_out(chain_out), .done(done)
  );

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h3C;
  endfunction

  assign mem_data = mem_f(mem_addr);

  // monitor, samples at negedge
  int rd_n = 0, rise_n = 0, neg_t = 0, chg_hi = 0;
  logic prev_cc = 1'b0;
  logic [2:0] prev_out = 3'b001;
  logic [15:0] rec_addr [0:63];
  logic [2:0]  rec_bit  [0:511];
  int          rec_t    [0:511];

  always @(negedge clk) begin
    neg_t = neg_t + 1;
    if (mem_rd) begin
      if (rd_n < 64) rec_addr[rd_n] = mem_addr;
      rd_n = rd_n + 1;
    end
    if (cfg_clk && !prev_cc) begin
      if (rise_n < 512) begin
        rec_bit[rise_n] = {keep_en, keep_data, chain_out};
        rec_t[rise_n]   = neg_t;
      end
      rise_n = rise_n + 1;
    end
    if (cfg_clk && prev_cc && ({keep_en, keep_data, chain_out} != prev_out))
      chg_hi = chg_hi + 1;
    prev_cc  = cfg_clk;
    prev_out = {keep_en, keep_data, chain_out};
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start(input logic m, input int kb, input int tb);
    @(negedge clk);
    mode_desc   = m;
    keep_bits   = CNT_W'(kb);
    stream_bits = CNT_W'(tb);
    start = 1'b1;
    @(posedge clk);
    #1;
    rd_n = 0; rise_n = 0; chg_hi = 0; prev_cc = 1'b0;
    @(negedge clk);
    start = 1'b0;
    // R10: inputs changed after start must not matter
    mode_desc   = ~m;
    keep_bits   = CNT_W'(kb + 3);
    stream_bits = CNT_W'(tb + 9);
  endtask

  task automatic run_job(input string name, input logic m, input int kb, input int tb);
    int waitc, exp_rd, bad_addr, bad_bit, bad_sp, first_bad, snap_rd, snap_rise;
    logic [15:0] a;
    logic b;
    logic [2:0] e;
    pulse_start(m, kb, tb);
    waitc = 0;
    while (!done && waitc < 20000) begin
      @(negedge clk);
      waitc++;
    end
    check(done == 1'b1, "R9", {name, " done reached"}, done, 1);
    if (tb == 0) check(waitc == 0, "R11", {name, " done at once"}, waitc, 0);
    exp_rd = (tb + 7) / 8;
    check(rd_n == exp_rd, "R8", {name, " read count"}, rd_n, exp_rd);
    check(rise_n == tb, "R9", {name, " cfg_clk rising edges"}, rise_n, tb);
    bad_addr = 0; first_bad = -1;
    for (int k = 0; k < rd_n && k < 64; k++) begin
      a = m ? 16'(16'hFFFF - k) : 16'(k);
      if (rec_addr[k] != a) begin
        bad_addr++;
        if (first_bad < 0) first_bad = k;
      end
    end
    check(bad_addr == 0, m ? "R3" : "R2", {name, " address sequence, first bad index"},
          first_bad, -1);
    bad_bit = 0; first_bad = -1;
    for (int n = 0; n < rise_n && n < 512; n++) begin
      a = m ? 16'(16'hFFFF - n / 8) : 16'(n / 8);
      b = mem_f(a)[n % 8];
      e = (n < kb) ? {1'b1, b, 1'b1} : {1'b0, 1'b0, b};
      if (rec_bit[n] != e) begin
        bad_bit++;
        if (first_bad < 0) first_bad = n;
      end
    end
    check(bad_bit == 0, "R4 R6 R7", {name, " stream bits, first bad index"}, first_bad, -1);
    check(chg_hi == 0, "R4", {name, " output change while cfg_clk high"}, chg_hi, 0);
    bad_sp = 0;
    for (int n = 1; n < rise_n && n < 512; n++)
      if (rec_t[n] - rec_t[n-1] != 2 * HALF) bad_sp++;
    check(bad_sp == 0, "R5", {name, " rising edge spacing errors"}, bad_sp, 0);
    snap_rd = rd_n; snap_rise = rise_n;
    repeat (12) @(negedge clk);
    check(done && !cfg_clk && rd_n == snap_rd && rise_n == snap_rise, "R9",
          {name, " quiet while done (new reads+edges)"},
          (rd_n - snap_rd) + (rise_n - snap_rise), 0);
  endtask

  task automatic t_reset;
    check(!mem_rd && !cfg_clk && !done && !keep_en && !keep_data, "R1",
          "reset outputs low", {mem_rd, cfg_clk, done, keep_en, keep_data}, 0);
    check(chain_out == 1'b1, "R1", "reset chain_out", chain_out, 1);
    check(mem_addr == 16'h0000, "R1", "reset address", mem_addr, 0);
    rd_n = 0; rise_n = 0;
    repeat (20) @(negedge clk);
    check(rd_n == 0 && rise_n == 0 && !done, "R1", "idle without start", rd_n + rise_n, 0);
  endtask

  task automatic t_restart;
    int waitc;
    pulse_start(1'b0, 16, 64);
    waitc = 0;
    while (rise_n < 10 && waitc < 5000) begin
      @(negedge clk);
      waitc++;
    end
    check(rise_n >= 10 && !done, "R10", "first load under way", rise_n, 10);
    run_job("R10 restart desc", 1'b1, 12, 30);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_job("R2 asc", 1'b0, 20, 40);
    run_job("R3 desc odd len", 1'b1, 8, 13);
    run_job("R7 all chain", 1'b0, 0, 16);
    run_job("R6 all local", 1'b1, 50, 24);
    run_job("R11 zero length", 1'b0, 4, 0);
    t_restart();
    run_job("R5 long", 1'b0, 100, 200);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule